// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block builds a 32-bit single-error-correcting Hamming code over the main area of one NAND page while the data words stream past. The same datapath serves both directions. On a program, the finished code is taken from `ecc_out` and stored in the spare area. On a read, the code fetched from the spare area is applied on `ecc_stored`, and the block classifies the mismatch between the stored code and the code it has just recomputed.

A `page_start` pulse clears the accumulator and arms the block. Each cycle with `dv` high then adds one main-area word. The page is either 8 or 16 bits wide and holds 512, 1024, 2048 or 4096 words. After the last word of the main area, the code is frozen and the status is published. Any later transfers, such as spare-area bytes, are ignored until the next `page_start`.

Top module: `nand_page_ecc`

## Requirements
- R1: After reset, and in the cycle after a `page_start` pulse, `ecc_out` is all zero and `done` is 0.
- R2: Column parity covers the bit position `p` (0..7) inside each byte. For k in 0..2, code bit 2k is the XOR of all data bits with p[k]=0, and code bit 2k+1 is the XOR of all data bits with p[k]=1.
- R3: Line parity covers the byte index `b` within the page. For j in 0..12, code bit 6+2j is the parity of all bytes with b[j]=0, and code bit 7+2j is the parity of all bytes with b[j]=1.
- R4: With `wide16`=1, word w is treated as byte 2w (bits 7:0) followed by byte 2w+1 (bits 15:8). With `wide16`=0, word w is byte w, and `din[15:8]` has no effect.
- R5: The number of index bits in use is 9 + `page_sel` + `wide16`. Line pairs at or above that count stay 0 in `ecc_out`.
- R6: The page holds 512 << `page_sel` words. `done` rises in the cycle after the last word is accepted. It then holds, together with an unchanged `ecc_out`, until the next `page_start`, and words offered with `dv` in that interval have no effect.
- R7: A `dv` word presented in the same cycle as `page_start` is discarded.
- R8: While `done` is high, `st_clean` is 1 if `ecc_stored` equals `ecc_out`.
- R9: While `done` is high, `st_fixable` is 1 when every in-use pair of the syndrome (`ecc_stored` XOR `ecc_out`) has exactly one bit set and all bits outside the in-use pairs are 0. In that case, `err_word` gives the failing word and `err_bit` gives the failing bit inside it (0..15 in 16-bit mode).
- R10: While `done` is high, `st_eccbit` is 1 if the syndrome has exactly one bit set, which marks an error in the stored code itself.
- R11: While `done` is high, `st_multi` is 1 for any other nonzero syndrome.
- R12: The four status flags are all 0 while `done` is 0, and exactly one of them is 1 while `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_start | input | 1 | Clears the accumulator and starts a page |
| wide16 | input | 1 | 1 = 16-bit data words, 0 = 8-bit |
| page_sel | input | 2 | Main-area size: 512 << page_sel words |
| dv | input | 1 | Data word valid |
| din | input | 16 | Data word |
| ecc_stored | input | 32 | Code read back from the spare area |
| ecc_out | output | 32 | Accumulated code |
| done | output | 1 | Main area complete, code and status valid |
| st_clean | output | 1 | No error |
| st_fixable | output | 1 | Correctable single-bit error |
| st_eccbit | output | 1 | Single-bit error in the stored code |
| st_multi | output | 1 | Uncorrectable error |
| err_word | output | 12 | Index of the failing word |
| err_bit | output | 4 | Bit position inside the failing word |

## Verification
Two functions can meet in one cycle. The first is the clear performed by `page_start` colliding with a data word. The bench provokes this by raising `dv` with an all-ones word in the `page_start` cycle, then checks that the finished page code equals the model code for the page alone. The second is the end-of-page freeze meeting further data. The bench keeps `dv` high with fresh words right after the last word and checks that both `ecc_out` and `done` stay unchanged.

// File: rtl/nand_page_ecc.sv
module nand_page_ecc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        page_start,
  input  logic        wide16,
  input  logic [1:0]  page_sel,
  input  logic        dv,
  input  logic [15:0] din,
  input  logic [31:0] ecc_stored,
  output logic [31:0] ecc_out,
  output logic        done,
  output logic        st_clean,
  output logic        st_fixable,
  output logic        st_eccbit,
  output logic        st_multi,
  output logic [11:0] err_word,
  output logic [3:0]  err_bit
);
  localparam int LPAIRS = 13;

  logic [11:0] wcnt;
  logic [31:0] acc, upd, syn, use_m;
  logic [3:0]  nbits;
  logic [11:0] last_w;
  logic [7:0]  lo, hi;
  logic [12:0] bidx, hidx, loc;
  logic        pairs_ok, fixable_raw;

  assign nbits  = 4'd9 + {2'b00, page_sel} + {3'b000, wide16};
  assign last_w = 12'((13'd512 << page_sel) - 13'd1);
  assign lo     = din[7:0];
  assign hi     = wide16 ? din[15:8] : 8'h00;
  assign bidx   = wide16 ? {wcnt, 1'b0} : {1'b0, wcnt};
  assign hidx   = bidx | 13'd1;

  always_comb begin
    upd = '0;
    for (int k = 0; k < 3; k++)
      for (int q = 0; q < 8; q++)
        upd[2*k + ((q >> k) & 1)] ^= lo[q] ^ hi[q];
    for (int j = 0; j < LPAIRS; j++)
      if (j < int'(nbits)) begin
        upd[6 + 2*j + int'(bidx[j])] ^= ^lo;
        upd[6 + 2*j + int'(hidx[j])] ^= ^hi;
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc  <= '0;
      wcnt <= '0;
      done <= 1'b0;
    end else if (page_start) begin
      acc  <= '0;
      wcnt <= '0;
      done <= 1'b0;
    end else if (dv && !done) begin
      acc  <= acc ^ upd;
      wcnt <= wcnt + 12'd1;
      if (wcnt == last_w) done <= 1'b1;
    end

  assign ecc_out = acc;
  assign syn     = ecc_stored ^ acc;

  always_comb begin
    use_m    = 32'h0000_003F;
    pairs_ok = (syn[0] ^ syn[1]) & (syn[2] ^ syn[3]) & (syn[4] ^ syn[5]);
    loc      = '0;
    for (int j = 0; j < LPAIRS; j++)
      if (j < int'(nbits)) begin
        use_m[6 + 2*j]     = 1'b1;
        use_m[7 + 2*j]     = 1'b1;
        pairs_ok           = pairs_ok & (syn[6 + 2*j] ^ syn[7 + 2*j]);
        loc[j]             = syn[7 + 2*j];
      end
  end

  assign fixable_raw = pairs_ok && ((syn & ~use_m) == '0);
  assign st_clean    = done && (syn == '0);
  assign st_eccbit   = done && ($countones(syn) == 1);
  assign st_fixable  = done && fixable_raw;
  assign st_multi    = done && !st_clean && !st_eccbit && !st_fixable;
  assign err_word    = !st_fixable ? '0 : (wide16 ? loc[12:1] : loc[11:0]);
  assign err_bit     = !st_fixable ? '0 :
                       (wide16 ? {loc[0], syn[5], syn[3], syn[1]} : {1'b0, syn[5], syn[3], syn[1]});

  // R1
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_start |=> (!done && ecc_out == '0));
  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !page_start) |=> done);
  // R6
  ecc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !page_start) |=> $stable(ecc_out));
  // R5
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !page_start |-> ((ecc_out & ~use_m) == '0));
  // R12
  status_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({st_clean, st_fixable, st_eccbit, st_multi}) == 1));
  // R12
  status_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ({st_clean, st_fixable, st_eccbit, st_multi} == 4'b0000));
endmodule

// File: tb/sim_nand_page_ecc.sv
module sim_nand_page_ecc;
  logic clk = 0, rst_n = 0, page_start = 0, wide16 = 0, dv = 0;
  logic [1:0] page_sel = 0;
  logic [15:0] din = 0;
  logic [31:0] ecc_stored = 0, ecc_out;
  logic done, st_clean, st_fixable, st_eccbit, st_multi;
  logic [11:0] err_word;
  logic [3:0] err_bit;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nand_page_ecc u0 (.clk, .rst_n, .page_start, .wide16, .page_sel, .dv, .din, .ecc_stored,
    .ecc_out, .done, .st_clean, .st_fixable, .st_eccbit, .st_multi, .err_word, .err_bit);

  // entry: {kind[1:0] 0 clean 1 single 2 codebit 3 multi, wide, sel[1:0], seed[7:0]}
  localparam logic [12:0] VEC [0:7] = '{
    {2'd0, 1'b0, 2'd0, 8'd1}, {2'd0, 1'b1, 2'd3, 8'd2}, {2'd1, 1'b0, 2'd1, 8'd3},
    {2'd1, 1'b1, 2'd0, 8'd4}, {2'd2, 1'b1, 2'd2, 8'd5}, {2'd3, 1'b0, 2'd0, 8'd6},
    {2'd1, 1'b1, 2'd3, 8'd7}, {2'd0, 1'b0, 2'd3, 8'd8}};

  function automatic logic [15:0] pat(int i, int seed);
    return 16'((i * 40503 + seed * 7919) ^ (i >> 2) ^ (seed << 5));
  endfunction

  function automatic logic [15:0] word_at(bit w, int i, int seed, int fw, int fb, int fw2, int fb2);
    logic [15:0] d = pat(i, seed);
    if (i == fw) d[fb] = ~d[fb];
    if (i == fw2) d[fb2] = ~d[fb2];
    return d;
  endfunction

  function automatic logic [31:0] model(bit w, int sel, int seed, int fw, int fb, int fw2, int fb2);
    logic [31:0] e = 0;
    int words = 512 << sel;
    int nb = 9 + sel + int'(w);
    for (int i = 0; i < words; i++) begin
      logic [15:0] d = word_at(w, i, seed, fw, fb, fw2, fb2);
      for (int q = 0; q < (w ? 16 : 8); q++)
        if (d[q]) begin
          int bi = w ? 2 * i + q / 8 : i;
          int pos = q % 8;
          for (int k = 0; k < 3; k++) e[2*k + ((pos >> k) & 1)] ^= 1'b1;
          for (int j = 0; j < nb; j++) e[6 + 2*j + ((bi >> j) & 1)] ^= 1'b1;
        end
    end
    return e;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_page(bit w, int sel, int seed, int fw, int fb, int fw2, int fb2,
                          bit gaps, bit collide, logic [31:0] stored);
    int words = 512 << sel;
    @(negedge clk);
    page_start = 1; wide16 = w; page_sel = 2'(sel); ecc_stored = stored;
    dv = collide; din = 16'hffff;
    @(negedge clk);
    page_start = 0; dv = 0;
    chk(ecc_out == 0 && !done, "R1 cleared after start", {done, ecc_out[30:0]}, 0);
    chk({st_clean, st_fixable, st_eccbit, st_multi} == 0, "R12 idle status",
        {st_clean, st_fixable, st_eccbit, st_multi}, 0);
    for (int i = 0; i < words; i++) begin
      if (gaps && i % 7 == 3) begin dv = 0; @(negedge clk); end
      dv = 1; din = word_at(w, i, seed, fw, fb, fw2, fb2);
      if (i == words - 1) chk(!done, "R6 done low before last", done, 0);
      @(negedge clk);
    end
    dv = 0;
    chk(done, "R6 done after last", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ecc_out == 0 && !done, "R1 reset state", {done, ecc_out[30:0]}, 0);
    chk({st_clean, st_fixable, st_eccbit, st_multi} == 0, "R12 reset status",
        {st_clean, st_fixable, st_eccbit, st_multi}, 0);
    rst_n = 1;

    for (int v = 0; v < 8; v++) begin
      int kind = int'(VEC[v][12:11]);
      bit w = VEC[v][10];
      int sel = int'(VEC[v][9:8]);
      int seed = int'(VEC[v][7:0]);
      int words = 512 << sel;
      int fw = -1, fb = 0, fw2 = -1, fb2 = 0, nb = 9 + sel + int'(w);
      logic [31:0] clean = model(w, sel, seed, -1, 0, -1, 0);
      logic [31:0] stored = clean, exp;
      if (kind == 1) begin
        fw = (seed * 97) % words; fb = seed % (w ? 16 : 8);
        if (seed == 7) begin fw = words - 1; fb = 15; end
      end
      if (kind == 2) stored = clean ^ (32'h1 << 15);
      if (kind == 3) begin fw = 5; fb = 1; fw2 = 300; fb2 = 6; end
      exp = model(w, sel, seed, fw, fb, fw2, fb2);
      run_page(w, sel, seed, fw, fb, fw2, fb2, v % 2 == 1, 1'b0, stored);
      chk(ecc_out == exp, w ? "R4 R2 R3 16-bit code" : "R2 R3 8-bit code", ecc_out, exp);
      if (nb < 13) chk((ecc_out >> (6 + 2 * nb)) == 0, "R5 unused pairs", ecc_out, exp);
      case (kind)
        0: chk(st_clean && !st_fixable && !st_eccbit && !st_multi, "R8 clean",
               {st_clean, st_fixable, st_eccbit, st_multi}, 4'b1000);
        1: begin
          chk(st_fixable && !st_clean && !st_eccbit && !st_multi, "R9 fixable",
              {st_clean, st_fixable, st_eccbit, st_multi}, 4'b0100);
          chk(err_word == 12'(fw) && err_bit == 4'(fb), "R9 location",
              {err_word, err_bit}, {12'(fw), 4'(fb)});
        end
        2: chk(st_eccbit && !st_clean && !st_fixable && !st_multi, "R10 code bit",
               {st_clean, st_fixable, st_eccbit, st_multi}, 4'b0010);
        default: chk(st_multi && !st_clean && !st_fixable && !st_eccbit, "R11 multi",
               {st_clean, st_fixable, st_eccbit, st_multi}, 4'b0001);
      endcase
    end

    begin
      logic [31:0] clean = model(1'b0, 0, 9, -1, 0, -1, 0);
      logic [31:0] held;
      run_page(1'b0, 0, 9, -1, 0, -1, 0, 1'b0, 1'b1, clean);
      chk(ecc_out == clean, "R7 collided word dropped", ecc_out, clean);
      held = ecc_out;
      for (int i = 0; i < 4; i++) begin
        dv = 1; din = 16'h1234 + 16'(i * 3);
        @(negedge clk);
      end
      dv = 0;
      chk(ecc_out == held && done, "R6 words after done ignored", ecc_out, held);
      chk(st_clean, "R8 clean after ignored words", st_clean, 1);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule